// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the standard 64-byte configuration header of a single bus function. Requests and replies move on two valid/ready streams. A request carries a byte address, a write flag, an access size and right-justified write data. The block takes one request, waits a fixed number of cycles and then returns read data together with an error flag. The request side is ready only while no reply is pending. A reply stays on the response channel, with its data held steady, until the consumer raises `resp_ready`. A request is accepted on any clock edge where `req_valid` and `req_ready` are both high.

The header contains fixed identification fields and a few writable control bytes. It also has six base address registers and an expansion ROM register. A write of all ones to a base address register reads back as a size mask built from that register's size parameter. The low type bits stay fixed, so system firmware can probe the size. Any other full-word write sets the base. Each base address register drives a decoded base address and an enable onto side outputs, and downstream address decoders use these to claim I/O or memory space.

Top module: `cfg_header_regs`

## Requirements
- R1: Only access sizes 1, 2 and 4 are legal. Any other `req_size` returns `resp_err`=1 and read data 0, and the access changes no state.
- R2: An access to an address at or above 0x40 returns `resp_err`=1 and changes no state.
- R3: A 2-byte access at an odd address, or a 4-byte access whose address bits [1:0] are not 0, returns `resp_err`=1 and changes no state.
- R4: Reads are little-endian. The result is the 32-bit word at address[7:2], shifted right by 8×address[1:0] and cut to the access size. The word layouts are:
  - word 0: device ID in bits [31:16], vendor ID in bits [15:0];
  - word 2: class in bits [31:24], subclass in [23:16], programming interface (0) in [15:8], revision in [7:0];
  - word 15: maximum latency in [31:24], minimum grant in [23:16], interrupt pin in [15:8], interrupt line in [7:0].
  - Header words that are not implemented read 0.
- R5: Writes of any legal size update only these bytes: command (0x04–0x05), cache line size (0x0C), latency timer (0x0D) and interrupt line (0x3C). Write data is right-justified. Writes to status, revision, class, interrupt pin and the other fixed bytes are ignored.
- R6: A 4-byte write of 0xFFFFFFFF to a base address register (0x10 + 4n) loads it with ~(size−1), with the type bits unchanged. The write does not change that register's decode outputs.
- R7: Bit 0 of an I/O base address register is 1, and it protects bits [1:0]. A memory base address register protects bits [3:0], which read 0. Writes never change the protected bits, and 1- or 2-byte writes leave a base address register unchanged.
- R8: Any other 4-byte write to base address register n stores the unprotected bits. If those bits are nonzero, `bar_base[n]` takes them and `bar_en[n]` goes to 1. If they are zero, the decode outputs keep their previous values.
- R9: After reset, `bar_en` is 0, each base address register reads back only its type bits, and command reads 0.
- R10: A 4-byte write of 0xFFFFFFFE to 0x30 makes the ROM register read 0xFFFFFFFF. Any other 4-byte write there is stored as written.
- R11: A reply appears exactly RESP_LAT cycles after a request is accepted. `req_ready` is low while a reply is outstanding. A stalled reply keeps its data and error flag until `resp_ready` is high. A write reply carries data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 8 | Byte address in the header |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Right-justified write data |
| resp_valid | output | 1 | Reply present |
| resp_ready | input | 1 | Consumer takes the reply |
| resp_rdata | output | 32 | Right-justified read data |
| resp_err | output | 1 | 1 = access rejected |
| bar_base | output | 192 | Decoded base of each base address register; register n uses bits [32n+31:32n] |
| bar_en | output | 6 | Decode enable of each base address register |

## Verification
The assertions rely on the requester following stream rules: request fields stay stable while `req_valid` waits for `req_ready`, and reset is held for at least one edge. The bench drives each request at a falling edge and keeps it until it sees `req_ready` high. It then drops `req_valid` after that handshake edge. `resp_ready` follows a repeating pattern with gaps, so the stalled-reply path runs often.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int NUM_BARS  = 6;
  localparam int DATA_W    = 32;
  localparam int BAR_WORD0 = 4;   // words 4..9 hold the base address registers
  localparam int ROM_WORD  = 12;
  localparam int IRQ_WORD  = 15;

  // byte enables for an access of a given size at a byte lane
  function automatic logic [3:0] lane_enables(input logic [2:0] size, input logic [1:0] lane);
    case (size)
      3'd1:    return 4'b0001 << lane;
      3'd2:    return 4'b0011 << lane;
      3'd4:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/cfg_access_check.sv
module cfg_access_check
  import cfg_hdr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SPEC_BASE = 'h40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic              err,
  output logic [ADDR_W-3:0] word,
  output logic [3:0]        be
);
  logic size_ok, align_ok, range_ok;

  always_comb begin
    size_ok  = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    if (size == 3'd4)      align_ok = (addr[1:0] == 2'b00);
    else if (size == 3'd2) align_ok = !addr[0];
    else                   align_ok = 1'b1;
    range_ok = addr < ADDR_W'(SPEC_BASE);
    err      = !(size_ok && align_ok && range_ok);
    word     = addr[ADDR_W-1:2];
    be       = err ? 4'b0000 : lane_enables(size, addr[1:0]);
  end
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
  parameter bit          IS_IO = 1'b0,
  parameter logic [31:0] SIZE  = 32'h1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] bar_q,
  output logic [31:0] base,
  output logic        en
);
  localparam logic [31:0] TMASK     = IS_IO ? 32'h3 : 32'hF;
  localparam logic [31:0] TYPE_BITS = IS_IO ? 32'h1 : 32'h0;
  localparam logic [31:0] SIZE_MASK = ~(SIZE - 32'd1) & ~TMASK;

  logic [31:0] addr_bits;
  assign addr_bits = wdata & ~TMASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_q <= TYPE_BITS;
      base  <= '0;
      en    <= 1'b0;
    end else if (wr_en) begin
      if (wdata == 32'hFFFF_FFFF) begin
        bar_q <= SIZE_MASK | (bar_q & TMASK);
      end else begin
        bar_q <= addr_bits | (bar_q & TMASK);
        if (addr_bits != '0) begin
          base <= addr_bits;
          en   <= 1'b1;
        end
      end
    end
  end

  AST_TYPE_BITS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_q & TMASK) == TYPE_BITS);  // R7
  AST_EN_HAS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (base != '0));  // R8
  AST_SIZING_KEEPS_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata == 32'hFFFF_FFFF) |=> ($stable(base) && $stable(en)));  // R6
endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfg_hdr_pkg::*;
#(
  parameter int                     ADDR_W     = 8,
  parameter int                     RESP_LAT   = 2,
  parameter logic [15:0]            VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0]            DEVICE_ID  = 16'h3C4D,
  parameter logic [7:0]             REVISION   = 8'h05,
  parameter logic [7:0]             PROG_IF    = 8'h00,
  parameter logic [7:0]             SUBCLASS   = 8'h00,
  parameter logic [7:0]             CLASS_CODE = 8'h02,
  parameter logic [7:0]             INT_PIN    = 8'h01,
  parameter logic [7:0]             MIN_GNT    = 8'h03,
  parameter logic [7:0]             MAX_LAT    = 8'h09,
  parameter logic [NUM_BARS-1:0]    BAR_IO     = 6'b001001,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZE   = {32'h40, 32'h10000, 32'h20,
                                                  32'h100000, 32'h1000, 32'h100}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic [2:0]               req_size,
  input  logic [31:0]              req_wdata,
  output logic                     resp_valid,
  input  logic                     resp_ready,
  output logic [31:0]              resp_rdata,
  output logic                     resp_err,
  output logic [NUM_BARS*32-1:0]   bar_base,
  output logic [NUM_BARS-1:0]      bar_en
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int CNT_W  = $clog2(RESP_LAT + 1);

  logic              acc, acc_err, wr_go;
  logic [WORD_W-1:0] word;
  logic [3:0]        be;
  logic [31:0]       wr_word, rd_word, rd_shift, rd_sized;

  assign acc     = req_valid && req_ready;
  assign wr_go   = acc && req_write && !acc_err;
  assign wr_word = req_wdata << {req_addr[1:0], 3'b000};

  cfg_access_check #(.ADDR_W(ADDR_W)) u_chk (
    .addr(req_addr), .size(req_size), .err(acc_err), .word(word), .be(be)
  );

  // writable control bytes
  logic [15:0] cmd_q;
  logic [7:0]  cline_q, lat_q, irq_line_q;
  logic [31:0] rom_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      cline_q    <= '0;
      lat_q      <= '0;
      irq_line_q <= '0;
      rom_q      <= '0;
    end else if (wr_go) begin
      if (word == WORD_W'(1)) begin
        for (int b = 0; b < 2; b++)
          if (be[b]) cmd_q[8*b +: 8] <= wr_word[8*b +: 8];
      end
      if (word == WORD_W'(3)) begin
        if (be[0]) cline_q <= wr_word[7:0];
        if (be[1]) lat_q   <= wr_word[15:8];
      end
      if (word == WORD_W'(IRQ_WORD) && be[0]) irq_line_q <= wr_word[7:0];
      if (word == WORD_W'(ROM_WORD) && be == 4'hF)
        rom_q <= (req_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : req_wdata;
    end
  end

  // base address registers
  logic [31:0] bar_val [NUM_BARS];

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
    cfg_bar_slot #(.IS_IO(BAR_IO[g]), .SIZE(BAR_SIZE[g*32 +: 32])) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_go && be == 4'hF && word == WORD_W'(BAR_WORD0 + g)),
      .wdata (req_wdata),
      .bar_q (bar_val[g]),
      .base  (bar_base[g*32 +: 32]),
      .en    (bar_en[g])
    );
  end

  // read path
  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_BARS; i++)
      if (word == WORD_W'(BAR_WORD0 + i)) rd_word = bar_val[i];
    case (word)
      WORD_W'(0):        rd_word = {DEVICE_ID, VENDOR_ID};
      WORD_W'(1):        rd_word = {16'h0000, cmd_q};
      WORD_W'(2):        rd_word = {CLASS_CODE, SUBCLASS, PROG_IF, REVISION};
      WORD_W'(3):        rd_word = {16'h0000, lat_q, cline_q};
      WORD_W'(ROM_WORD): rd_word = rom_q;
      WORD_W'(IRQ_WORD): rd_word = {MAX_LAT, MIN_GNT, INT_PIN, irq_line_q};
      default: ;
    endcase
    rd_shift = rd_word >> {req_addr[1:0], 3'b000};
    case (req_size)
      3'd1:    rd_sized = {24'h0, rd_shift[7:0]};
      3'd2:    rd_sized = {16'h0, rd_shift[15:0]};
      default: rd_sized = rd_shift;
    endcase
  end

  // fixed-latency reply stage
  logic             busy_q, err_q;
  logic [CNT_W-1:0] wait_q;
  logic [31:0]      rdata_q;

  assign req_ready  = !busy_q;
  assign resp_valid = busy_q && (wait_q == '0);
  assign resp_rdata = rdata_q;
  assign resp_err   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wait_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (acc) begin
      busy_q  <= 1'b1;
      wait_q  <= CNT_W'(RESP_LAT - 1);
      rdata_q <= (req_write || acc_err) ? 32'h0 : rd_sized;
      err_q   <= acc_err;
    end else if (busy_q) begin
      if (wait_q != '0)    wait_q <= wait_q - 1'b1;
      else if (resp_ready) busy_q <= 1'b0;
    end
  end

  // latency observer for the reply-timing check
  logic [CNT_W-1:0] since_acc;
  always_ff @(posedge clk) begin
    if (!rst_n)                                      since_acc <= '0;
    else if (acc)                                    since_acc <= '0;
    else if (busy_q && since_acc != CNT_W'(RESP_LAT)) since_acc <= since_acc + 1'b1;
  end

  AST_REPLY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> (since_acc == CNT_W'(RESP_LAT - 1)));  // R11
  AST_REPLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_rdata) && $stable(resp_err)));  // R11
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);  // R11
  AST_BAD_ACCESS_NO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && acc_err) |=> ($stable(bar_en) && $stable(bar_base) && $stable(cmd_q)));  // R1
  AST_HIGH_OFFSET_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_addr >= ADDR_W'('h40)) |=> err_q);  // R2
  AST_WRITE_REPLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> (rdata_q == 32'h0));  // R11
endmodule

// File: tb/tb_cfg_header_regs.sv
`timescale 1ns/1ps
module tb_cfg_header_regs;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [7:0]   req_addr = '0;
  logic         req_write = 1'b0;
  logic [2:0]   req_size = 3'd4;
  logic [31:0]  req_wdata = '0;
  logic         resp_valid;
  logic         resp_ready;
  logic [31:0]  resp_rdata;
  logic         resp_err;
  logic [191:0] bar_base;
  logic [5:0]   bar_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] q_data[$];
  bit          q_err[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  logic [2:0] rcnt = '0;
  always @(posedge clk) rcnt <= rcnt + 3'd1;
  assign resp_ready = (rcnt != 3'd2) && (rcnt != 3'd5);

  cfg_header_regs #(.RESP_LAT(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_rdata(resp_rdata), .resp_err(resp_err),
    .bar_base(bar_base), .bar_en(bar_en)
  );

  task automatic check(input string tag, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: pushes the expected reply, then performs the handshake
  task automatic xfer(input logic [7:0] a, input bit w, input logic [2:0] sz,
                      input logic [31:0] wd, input logic [31:0] ed, input bit ee,
                      input string tag);
    q_data.push_back(ed);
    q_err.push_back(ee);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_size = sz; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] ed, input string tag);
    xfer(a, 1'b0, sz, 32'h0, ed, 1'b0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] wd, input string tag);
    xfer(a, 1'b1, sz, wd, 32'h0, 1'b0, tag);
  endtask

  task automatic drain();
    while (q_data.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: compares each reply against the scoreboard
  always @(negedge clk) begin
    if (rst_n && resp_valid && resp_ready) begin
      if (q_data.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected reply actual=%0h expected=none", resp_rdata);
      end else begin
        check({q_tag[0], " data"}, {160'h0, resp_rdata}, {160'h0, q_data[0]});
        check({q_tag[0], " err"}, {191'h0, resp_err}, {191'h0, q_err[0]});
        void'(q_data.pop_front());
        void'(q_err.pop_front());
        void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 bar_en at reset", {186'h0, bar_en}, 192'h0);
    check("R11 ready at reset", {191'h0, req_ready}, 192'h1);
    check("R11 no reply at reset", {191'h0, resp_valid}, 192'h0);

    rd(8'h00, 3'd4, 32'h3C4D_1A2B, "R4 id word");
    rd(8'h01, 3'd1, 32'h0000_001A, "R4 byte lane");
    rd(8'h02, 3'd2, 32'h0000_3C4D, "R4 half lane");
    rd(8'h04, 3'd4, 32'h0000_0000, "R9 command reset");
    rd(8'h10, 3'd4, 32'h0000_0001, "R9 io bar reset");
    rd(8'h14, 3'd4, 32'h0000_0000, "R9 mem bar reset");

    wr(8'h08, 3'd1, 32'h0000_00FF, "R5 revision write");
    rd(8'h08, 3'd4, 32'h0200_0005, "R5 class fixed");
    wr(8'h04, 3'd2, 32'h0000_0147, "R5 command write");
    rd(8'h04, 3'd4, 32'h0000_0147, "R5 command read");
    wr(8'h04, 3'd4, 32'hFFFF_0006, "R5 status ignored");
    rd(8'h04, 3'd4, 32'h0000_0006, "R5 status read");
    wr(8'h0C, 3'd1, 32'h0000_0010, "R5 cache line");
    wr(8'h0D, 3'd1, 32'h0000_0040, "R5 latency");
    rd(8'h0C, 3'd4, 32'h0000_4010, "R5 word3");
    wr(8'h3C, 3'd1, 32'h0000_000B, "R5 irq line");
    wr(8'h3D, 3'd1, 32'h0000_0077, "R5 irq pin");
    rd(8'h3C, 3'd4, 32'h0903_010B, "R4 word15");
    rd(8'h20, 3'd4, 32'h0000_0000, "R4 unused word");

    wr(8'h10, 3'd4, 32'hFFFF_FFFF, "R6 size io bar");
    rd(8'h10, 3'd4, 32'hFFFF_FF01, "R6 io mask");
    drain();
    check("R6 sizing leaves decode", {191'h0, bar_en[0]}, 192'h0);
    wr(8'h10, 3'd4, 32'h0000_C003, "R8 io base");
    rd(8'h10, 3'd4, 32'h0000_C001, "R7 io type kept");
    wr(8'h14, 3'd4, 32'hFFFF_FFFF, "R6 size mem bar");
    rd(8'h14, 3'd4, 32'hFFFF_F000, "R6 mem mask");
    wr(8'h14, 3'd4, 32'hFEB0_000F, "R8 mem base");
    rd(8'h14, 3'd4, 32'hFEB0_0000, "R7 mem low bits");
    wr(8'h18, 3'd4, 32'h0000_0000, "R8 zero write");
    wr(8'h1C, 3'd4, 32'hFFFF_FFFF, "R6 size io bar3");
    rd(8'h1C, 3'd4, 32'hFFFF_FFE1, "R6 io bar3 mask");
    wr(8'h10, 3'd1, 32'h0000_0000, "R7 byte write");
    rd(8'h10, 3'd4, 32'h0000_C001, "R7 byte write ignored");
    drain();
    check("R8 bar_en", {186'h0, bar_en}, {186'h0, 6'b000011});
    check("R8 base0", {160'h0, bar_base[31:0]}, {160'h0, 32'h0000_C000});
    check("R8 base1", {160'h0, bar_base[63:32]}, {160'h0, 32'hFEB0_0000});

    wr(8'h30, 3'd4, 32'hFFFF_FFFE, "R10 rom sentinel");
    rd(8'h30, 3'd4, 32'hFFFF_FFFF, "R10 rom ones");
    wr(8'h30, 3'd4, 32'h1234_5678, "R10 rom store");
    rd(8'h30, 3'd4, 32'h1234_5678, "R10 rom read");

    xfer(8'h00, 1'b0, 3'd3, 32'h0, 32'h0, 1'b1, "R1 size3");
    xfer(8'h04, 1'b1, 3'd0, 32'hFFFF, 32'h0, 1'b1, "R1 size0 write");
    rd(8'h04, 3'd4, 32'h0000_0006, "R1 no state change");
    xfer(8'h40, 1'b0, 3'd4, 32'h0, 32'h0, 1'b1, "R2 read 0x40");
    xfer(8'hFC, 1'b1, 3'd4, 32'h0000_1000, 32'h0, 1'b1, "R2 write high");
    xfer(8'h11, 1'b1, 3'd4, 32'h0, 32'h0, 1'b1, "R3 misaligned word");
    xfer(8'h05, 1'b1, 3'd2, 32'hAAAA, 32'h0, 1'b1, "R3 odd half");
    rd(8'h10, 3'd4, 32'h0000_C001, "R3 bar unchanged");
    rd(8'h04, 3'd4, 32'h0000_0006, "R3 command unchanged");
    drain();
    check("R1 decode kept", {186'h0, bar_en}, {186'h0, 6'b000011});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule